// File: doc/BRIEF.md
# NAND Cycle Sequencer

This block turns one high-level flash request into the ordered series of bus cycles that a raw NAND device needs. A request names an operation, an optional column, an optional page, a page mask that sets how many page-address bytes follow, the device page size and the bus width. The sequencer then walks through command bytes, address bytes and one data-transfer cycle. For each cycle it raises exactly one start strobe for one clock and presents a byte. It then waits for a completion pulse from the pin-timing engine before it moves on.

Sub-page reads are widened to full-page transfers: every read variant reaches the device as a plain read at column 0. The caller learns where its data sits through a returned column pointer and a spare-only flag. Devices with pages above 512 bytes get a second column byte and a read-confirm command. A program request first reads the page into the buffer and then opens a serial-input sequence.

Top module: `nand_cycle_seq`

## Requirements
- R1: Read operations (op 0 page read, op 1 upper-half read, op 2 spare-only read) issue the command byte 0x00. Then come column cycles carrying 0, the page cycles, the command byte 0x30 when page_bytes > 512, and finally one data-out transfer (start bit 3, byte 0x00).
- R2: Column cycles appear only when a column is used (always for reads, otherwise when req_col_vld is 1). The low byte goes first. A second cycle carrying column bits 15:8 appears only when page_bytes > 512.
- R3: Page cycles appear when req_page_vld is 1, one byte at a time, least significant byte first. After each byte the page and the mask both shift right by 8, and the cycles stop once the shifted mask is zero, so a mask of 0 still gives exactly one page byte.
- R4: On acceptance, col_ptr becomes req_col when req_col_vld is 1 and 0 otherwise. An upper-half read (op 1) adds 256 to that value. spare_only becomes 1 for op 2 and 0 for every other accepted operation.
- R5: Program setup (op 3) runs the complete R1 read sequence. It then issues command byte 0x80, column cycles carrying 0 (per R2) and the page cycles again.
- R6: Program start (op 4) issues one data-in transfer (start bit 2, byte 0x00) followed by command byte 0x10, with no address cycles.
- R7: Erase operations issue command byte 0x60 (op 5) or 0xD0 (op 6), followed by the column and page cycles that were supplied.
- R8: Read ID (op 7) issues 0x90, the supplied address cycles and an ID transfer (start bit 4). Status read (op 8) issues 0x70, the supplied address cycles and a status transfer (start bit 5). After a status read, col_ptr is 1 if bus16 was 1 at acceptance and 0 otherwise.
- R9: cyc_start is single-hot with command on bit 0, address on bit 1, data-in on bit 2, data-out on bit 3, ID on bit 4 and status on bit 5. Each start lasts one clock, and the next start comes only after cyc_done has been seen for the current cycle.
- R10: Operation codes 9 to 15 are ignored. No cycle is issued, busy stays 0, and col_ptr and spare_only keep their values.
- R11: busy rises on the clock that accepts a request and falls on the clock that samples cyc_done for the final cycle. req_valid is ignored while busy is 1.
- R12: After reset, busy, cyc_start, col_ptr and spare_only are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_op | input | 4 | Operation code |
| req_col | input | 16 | Column address |
| req_col_vld | input | 1 | Column is supplied |
| req_page | input | PAGE_W | Page address |
| req_page_vld | input | 1 | Page is supplied |
| page_mask | input | PAGE_W | Mask setting the page-byte count |
| page_bytes | input | 16 | Device page size in bytes |
| bus16 | input | 1 | Device has a 16-bit bus |
| busy | output | 1 | Request in progress |
| cyc_start | output | 6 | Single-hot cycle start strobe |
| cyc_byte | output | 8 | Byte for the current cycle |
| cyc_done | input | 1 | Current cycle completed |
| col_ptr | output | 16 | Column pointer for buffer access |
| spare_only | output | 1 | Last accepted op was a spare-only read |

## Verification
The bench targets the following corner cases:
- A zero page mask must still give one page byte. A sequencer that tests the mask before sending would give no page byte.
- The page-size boundary at exactly 512 bytes must not add the high column byte or the 0x30 confirm. A design that compares with the wrong sign would add an extra address byte or drop the confirm.
- Program setup must restart its second phase at the saved page, not at the page left over after the read's shifts. Otherwise it would repeat zero bytes.
- Completion pulses are delayed at random, and a request is injected while the sequencer is busy. A sequencer that advances without a done pulse, or that accepts the new request, would reorder or corrupt the cycle list.

// File: rtl/nseq_pkg.sv
`timescale 1ns/1ps
package nseq_pkg;
  localparam logic [3:0] OP_RD         = 4'd0;
  localparam logic [3:0] OP_RD_HI      = 4'd1;
  localparam logic [3:0] OP_RD_SPARE   = 4'd2;
  localparam logic [3:0] OP_PROG_SETUP = 4'd3;
  localparam logic [3:0] OP_PROG_GO    = 4'd4;
  localparam logic [3:0] OP_ERASE_A    = 4'd5;
  localparam logic [3:0] OP_ERASE_B    = 4'd6;
  localparam logic [3:0] OP_RD_ID      = 4'd7;
  localparam logic [3:0] OP_STATUS     = 4'd8;

  localparam logic [7:0] NB_READ    = 8'h00;
  localparam logic [7:0] NB_CONFIRM = 8'h30;
  localparam logic [7:0] NB_SERIAL  = 8'h80;
  localparam logic [7:0] NB_PROG    = 8'h10;
  localparam logic [7:0] NB_ERASE_A = 8'h60;
  localparam logic [7:0] NB_ERASE_B = 8'hD0;
  localparam logic [7:0] NB_ID      = 8'h90;
  localparam logic [7:0] NB_STATUS  = 8'h70;

  // start-strobe bit positions
  localparam int SB_CMD  = 0;
  localparam int SB_ADDR = 1;
  localparam int SB_DIN  = 2;
  localparam int SB_DOUT = 3;
  localparam int SB_ID   = 4;
  localparam int SB_STAT = 5;
  localparam int SB_N    = 6;

  typedef enum logic [2:0] {S_CMD, S_COL_LO, S_COL_HI, S_PAGE, S_CONF, S_XFER} step_e;
  typedef enum logic [2:0] {T_NONE, T_READ, T_ID, T_STAT, T_PROG} tail_e;

  typedef struct packed {
    logic        ok;
    step_e       first;
    logic [7:0]  cmd;
    logic        use_col;
    logic [15:0] col_out;
    logic        use_page;
    tail_e       tail;
    logic        chain;
    logic [15:0] ptr;
    logic        spare;
  } plan_t;
endpackage

// File: rtl/nseq_decode.sv
`timescale 1ns/1ps
module nseq_decode
  import nseq_pkg::*;
(
  input  logic [3:0]  op,
  input  logic [15:0] col,
  input  logic        col_vld,
  input  logic        page_vld,
  output plan_t       plan
);
  logic [15:0] base;

  always_comb begin
    base          = col_vld ? col : 16'd0;
    plan          = '0;
    plan.first    = S_CMD;
    plan.tail     = T_NONE;
    plan.use_col  = col_vld;
    plan.col_out  = col;
    plan.use_page = page_vld;
    plan.ptr      = base;
    case (op)
      OP_RD, OP_RD_HI, OP_RD_SPARE, OP_PROG_SETUP: begin
        plan.ok      = 1'b1;
        plan.cmd     = NB_READ;
        plan.use_col = 1'b1;
        plan.col_out = 16'd0;
        plan.tail    = T_READ;
        plan.chain   = (op == OP_PROG_SETUP);
        plan.spare   = (op == OP_RD_SPARE);
        if (op == OP_RD_HI) plan.ptr = base + 16'd256;
      end
      OP_PROG_GO: begin
        plan.ok       = 1'b1;
        plan.first    = S_XFER;
        plan.cmd      = NB_PROG;
        plan.use_col  = 1'b0;
        plan.use_page = 1'b0;
        plan.tail     = T_PROG;
      end
      OP_ERASE_A: begin plan.ok = 1'b1; plan.cmd = NB_ERASE_A; end
      OP_ERASE_B: begin plan.ok = 1'b1; plan.cmd = NB_ERASE_B; end
      OP_RD_ID:   begin plan.ok = 1'b1; plan.cmd = NB_ID;     plan.tail = T_ID;   end
      OP_STATUS:  begin plan.ok = 1'b1; plan.cmd = NB_STATUS; plan.tail = T_STAT; end
      default: ;
    endcase
  end
endmodule

// File: rtl/nseq_strobe.sv
`timescale 1ns/1ps
module nseq_strobe
  import nseq_pkg::*;
(
  input  logic             fire,
  input  step_e            step,
  input  tail_e            tail,
  input  logic [7:0]       cmd,
  input  logic [15:0]      col,
  input  logic [7:0]       page_lo,
  output logic [SB_N-1:0]  start,
  output logic [7:0]       byte_o
);
  logic [2:0] sel;
  logic [7:0] val;

  always_comb begin
    sel = 3'(SB_CMD);
    val = 8'h00;
    case (step)
      S_CMD:    begin sel = 3'(SB_CMD);  val = cmd;        end
      S_COL_LO: begin sel = 3'(SB_ADDR); val = col[7:0];   end
      S_COL_HI: begin sel = 3'(SB_ADDR); val = col[15:8];  end
      S_PAGE:   begin sel = 3'(SB_ADDR); val = page_lo;    end
      S_CONF:   begin sel = 3'(SB_CMD);  val = NB_CONFIRM; end
      S_XFER: begin
        case (tail)
          T_PROG:  sel = 3'(SB_DIN);
          T_ID:    sel = 3'(SB_ID);
          T_STAT:  sel = 3'(SB_STAT);
          default: sel = 3'(SB_DOUT);
        endcase
      end
      default: ;
    endcase
  end

  for (genvar g = 0; g < SB_N; g++) begin : g_hot
    assign start[g] = fire && (sel == 3'(g));
  end
  assign byte_o = fire ? val : 8'h00;
endmodule

// File: rtl/nand_cycle_seq.sv
`timescale 1ns/1ps
module nand_cycle_seq
  import nseq_pkg::*;
#(
  parameter int PAGE_W     = 24,
  parameter int SMALL_PAGE = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [3:0]        req_op,
  input  logic [15:0]       req_col,
  input  logic              req_col_vld,
  input  logic [PAGE_W-1:0] req_page,
  input  logic              req_page_vld,
  input  logic [PAGE_W-1:0] page_mask,
  input  logic [15:0]       page_bytes,
  input  logic              bus16,
  output logic              busy,
  output logic [5:0]        cyc_start,
  output logic [7:0]        cyc_byte,
  input  logic              cyc_done,
  output logic [15:0]       col_ptr,
  output logic              spare_only
);
  localparam logic [15:0] SMALL_LIM = 16'(SMALL_PAGE);

  plan_t plan;
  nseq_decode u_dec (
    .op(req_op), .col(req_col), .col_vld(req_col_vld),
    .page_vld(req_page_vld), .plan(plan)
  );

  logic busy_q, busy_d, wait_q, wait_d, chain_q, chain_d;
  logic use_col_q, use_col_d, use_page_q, use_page_d;
  logic large_q, large_d, b16_q, b16_d, spare_q, spare_d;
  step_e step_q, step_d;
  tail_e tail_q, tail_d;
  logic [7:0]  cmd_q, cmd_d;
  logic [15:0] col_q, col_d, ptr_q, ptr_d;
  logic [PAGE_W-1:0] page_q, page_d, mask_q, mask_d, page0_q, page0_d, mask0_q, mask0_d;
  logic accept, fire, done_hit, to_page, to_tail;
  logic [PAGE_W-1:0] mask_sh;

  assign accept   = req_valid && !busy_q && plan.ok;
  assign fire     = busy_q && !wait_q;
  assign done_hit = busy_q && wait_q && cyc_done;
  assign mask_sh  = mask_q >> 8;

  always_comb begin
    busy_d = busy_q; wait_d = wait_q; chain_d = chain_q; step_d = step_q;
    tail_d = tail_q; cmd_d = cmd_q; col_d = col_q; ptr_d = ptr_q;
    use_col_d = use_col_q; use_page_d = use_page_q; large_d = large_q;
    b16_d = b16_q; spare_d = spare_q; page_d = page_q; mask_d = mask_q;
    page0_d = page0_q; mask0_d = mask0_q;
    to_page = 1'b0; to_tail = 1'b0;
    if (accept) begin
      busy_d = 1'b1; wait_d = 1'b0; step_d = plan.first; tail_d = plan.tail;
      chain_d = plan.chain; cmd_d = plan.cmd; col_d = plan.col_out;
      use_col_d = plan.use_col; use_page_d = plan.use_page;
      ptr_d = plan.ptr; spare_d = plan.spare;
      large_d = page_bytes > SMALL_LIM; b16_d = bus16;
      page_d = req_page; mask_d = page_mask; page0_d = req_page; mask0_d = page_mask;
    end else if (fire) begin
      wait_d = 1'b1;
    end else if (done_hit) begin
      wait_d = 1'b0;
      case (step_q)
        S_CMD:    if (use_col_q) step_d = S_COL_LO; else to_page = 1'b1;
        S_COL_LO: if (large_q) step_d = S_COL_HI; else to_page = 1'b1;
        S_COL_HI: to_page = 1'b1;
        S_PAGE: begin
          page_d = page_q >> 8;
          mask_d = mask_sh;
          if (mask_sh == '0) to_tail = 1'b1;
        end
        S_CONF:   step_d = S_XFER;
        S_XFER: begin
          if (tail_q == T_READ && chain_q) begin
            chain_d = 1'b0; tail_d = T_NONE; cmd_d = NB_SERIAL; col_d = 16'd0;
            use_col_d = 1'b1; page_d = page0_q; mask_d = mask0_q; step_d = S_CMD;
          end else if (tail_q == T_PROG) begin
            tail_d = T_NONE; step_d = S_CMD;
          end else begin
            if (tail_q == T_STAT) ptr_d = {15'd0, b16_q};
            busy_d = 1'b0;
          end
        end
        default: ;
      endcase
      if (to_page) begin
        if (use_page_q) step_d = S_PAGE; else to_tail = 1'b1;
      end
      if (to_tail) begin
        case (tail_q)
          T_READ:        step_d = large_q ? S_CONF : S_XFER;
          T_ID, T_STAT:  step_d = S_XFER;
          default:       busy_d = 1'b0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; wait_q <= 1'b0; chain_q <= 1'b0; step_q <= S_CMD;
      tail_q <= T_NONE; cmd_q <= 8'h00; col_q <= 16'd0; ptr_q <= 16'd0;
      use_col_q <= 1'b0; use_page_q <= 1'b0; large_q <= 1'b0; b16_q <= 1'b0;
      spare_q <= 1'b0; page_q <= '0; mask_q <= '0; page0_q <= '0; mask0_q <= '0;
    end else begin
      busy_q <= busy_d; wait_q <= wait_d; chain_q <= chain_d; step_q <= step_d;
      tail_q <= tail_d; cmd_q <= cmd_d; col_q <= col_d; ptr_q <= ptr_d;
      use_col_q <= use_col_d; use_page_q <= use_page_d; large_q <= large_d;
      b16_q <= b16_d; spare_q <= spare_d; page_q <= page_d; mask_q <= mask_d;
      if (accept) begin
        page0_q <= page0_d;
        mask0_q <= mask0_d;
      end
    end
  end

  nseq_strobe u_stb (
    .fire(fire), .step(step_q), .tail(tail_q), .cmd(cmd_q), .col(col_q),
    .page_lo(page_q[7:0]), .start(cyc_start), .byte_o(cyc_byte)
  );

  assign busy       = busy_q;
  assign col_ptr    = ptr_q;
  assign spare_only = spare_q;
endmodule

// File: rtl/nseq_chk.sv
`timescale 1ns/1ps
module nseq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [3:0] req_op,
  input logic       busy,
  input logic [5:0] cyc_start,
  input logic       cyc_done,
  input logic       spare_only
);
  // R9
  start_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cyc_start));
  // R9
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start != 6'd0) |=> (cyc_start == 6'd0));
  // R11
  start_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start != 6'd0) |-> busy);
  // R11
  fall_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(cyc_done));
  // R10
  unsupported_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && req_op > 4'd8) |=> !busy);
  // R4
  spare_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spare_only) |-> $past(req_valid && !busy && req_op == 4'd2));
endmodule

bind nand_cycle_seq nseq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
  .busy(busy), .cyc_start(cyc_start), .cyc_done(cyc_done), .spare_only(spare_only)
);

// File: tb/tb_nand_cycle_seq.sv
`timescale 1ns/1ps
module tb_nand_cycle_seq;
  localparam logic [5:0] K_CMD = 6'b000001, K_ADDR = 6'b000010, K_DIN = 6'b000100,
                         K_DOUT = 6'b001000, K_ID = 6'b010000, K_STAT = 6'b100000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_col_vld = 1'b0, req_page_vld = 1'b0, bus16 = 1'b0;
  logic cyc_done = 1'b0;
  logic [3:0] req_op = 4'd0;
  logic [15:0] req_col = 16'd0, page_bytes = 16'd512;
  logic [23:0] req_page = 24'd0, page_mask = 24'd0;
  logic busy, spare_only;
  logic [5:0] cyc_start;
  logic [7:0] cyc_byte;
  logic [15:0] col_ptr;

  nand_cycle_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_col(req_col), .req_col_vld(req_col_vld), .req_page(req_page),
    .req_page_vld(req_page_vld), .page_mask(page_mask), .page_bytes(page_bytes),
    .bus16(bus16), .busy(busy), .cyc_start(cyc_start), .cyc_byte(cyc_byte),
    .cyc_done(cyc_done), .col_ptr(col_ptr), .spare_only(spare_only)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [5:0] exp_s [64]; logic [7:0] exp_b [64]; int exp_n;
  logic [5:0] got_s [64]; logic [7:0] got_b [64]; int got_n;
  logic [15:0] m_ptr = 16'd0; bit m_spare = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic push(input logic [5:0] s, input logic [7:0] b);
    exp_s[exp_n] = s; exp_b[exp_n] = b; exp_n++;
  endtask

  task automatic m_addr(input logic [15:0] c, input bit cv, input logic [23:0] pg,
                        input bit pv, input logic [23:0] mk, input bit lg);
    if (cv) begin
      push(K_ADDR, c[7:0]);
      if (lg) push(K_ADDR, c[15:8]);
    end
    if (pv) begin
      do begin
        push(K_ADDR, pg[7:0]); pg = pg >> 8; mk = mk >> 8;
      end while (mk != 24'd0);
    end
  endtask

  task automatic m_read(input logic [23:0] pg, input bit pv, input logic [23:0] mk, input bit lg);
    push(K_CMD, 8'h00);
    m_addr(16'd0, 1'b1, pg, pv, mk, lg);
    if (lg) push(K_CMD, 8'h30);
    push(K_DOUT, 8'h00);
  endtask

  task automatic build(input logic [3:0] op, input logic [15:0] c, input bit cv,
                       input logic [23:0] pg, input bit pv, input logic [23:0] mk,
                       input logic [15:0] pb, input bit b16);
    bit lg = (pb > 16'd512);
    logic [15:0] base = cv ? c : 16'd0;
    exp_n = 0;
    if (op <= 4'd8) begin m_ptr = base; m_spare = (op == 4'd2); end
    case (op)
      4'd0, 4'd1, 4'd2: m_read(pg, pv, mk, lg);                   // R1
      4'd3: begin m_read(pg, pv, mk, lg); push(K_CMD, 8'h80);      // R5
                  m_addr(16'd0, 1'b1, pg, pv, mk, lg); end
      4'd4: begin push(K_DIN, 8'h00); push(K_CMD, 8'h10); end      // R6
      4'd5: begin push(K_CMD, 8'h60); m_addr(c, cv, pg, pv, mk, lg); end // R7
      4'd6: begin push(K_CMD, 8'hD0); m_addr(c, cv, pg, pv, mk, lg); end
      4'd7: begin push(K_CMD, 8'h90); m_addr(c, cv, pg, pv, mk, lg); push(K_ID, 8'h00); end // R8
      4'd8: begin push(K_CMD, 8'h70); m_addr(c, cv, pg, pv, mk, lg); push(K_STAT, 8'h00);
                  m_ptr = {15'd0, b16}; end
      default: ;                                                   // R10
    endcase
    if (op == 4'd1) m_ptr = base + 16'd256;                        // R4
  endtask

  task automatic run_op(input logic [3:0] op, input logic [15:0] c, input bit cv,
                        input logic [23:0] pg, input bit pv, input logic [23:0] mk,
                        input logic [15:0] pb, input bit b16, input bit inject);
    int pend = 0; int iter = 0;
    build(op, c, cv, pg, pv, mk, pb, b16);
    got_n = 0;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_col = c; req_col_vld = cv; req_page = pg;
    req_page_vld = pv; page_mask = mk; page_bytes = pb; bus16 = b16;
    @(negedge clk);
    req_valid = 1'b0;
    if (op <= 4'd8) check(busy == 1'b1, "R11", "busy after accept", busy, 1);
    else            check(busy == 1'b0, "R10", "busy on ignored op", busy, 0);
    while (1) begin
      if (cyc_done) cyc_done = 1'b0;
      if (inject && iter == 2) begin req_valid = 1'b1; req_op = 4'd8; end
      if (inject && iter == 3) req_valid = 1'b0;
      if (cyc_start != 6'd0) begin
        if (got_n < 64) begin got_s[got_n] = cyc_start; got_b[got_n] = cyc_byte; got_n++; end
        pend = 1 + int'($urandom % 3);
      end else if (pend > 0) begin
        pend--;
        if (pend == 0) cyc_done = 1'b1;
      end
      if (!busy && pend == 0 && !cyc_done) break;
      iter++;
      if (iter > 400) begin check(1'b0, "R11", "run did not finish", iter, 0); break; end
      @(negedge clk);
    end
    req_valid = 1'b0;
    check(got_n == exp_n, "R9", $sformatf("cycle count op%0d", op), got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      check(got_s[i] == exp_s[i], "R9", $sformatf("op%0d strobe %0d", op, i), got_s[i], exp_s[i]);
      check(got_b[i] == exp_b[i], (op > 4'd4) ? "R7" : "R2",
            $sformatf("op%0d byte %0d", op, i), got_b[i], exp_b[i]);
    end
    check(col_ptr == m_ptr, (op == 4'd8) ? "R8" : "R4", $sformatf("col_ptr op%0d", op), col_ptr, m_ptr);
    check(spare_only == m_spare, "R4", $sformatf("spare_only op%0d", op), spare_only, m_spare);
  endtask

  function automatic logic [15:0] pick_pb(input int k);
    case (k % 4)
      0: return 16'd512;
      1: return 16'd2048;
      2: return 16'd4096;
      default: return 16'd256;
    endcase
  endfunction

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12
    check(busy == 0, "R12", "busy after reset", busy, 0);
    check(cyc_start == 0, "R12", "start after reset", cyc_start, 0);
    check(col_ptr == 0, "R12", "col_ptr after reset", col_ptr, 0);
    check(spare_only == 0, "R12", "spare after reset", spare_only, 0);
    // R3: zero mask still gives one page byte, boundary 512 is small (R2)
    run_op(4'd0, 16'h1234, 1, 24'hABCDEF, 1, 24'h000000, 16'd512, 0, 0);
    // R1 large page, upper half pointer R4
    run_op(4'd1, 16'd10, 1, 24'h123456, 1, 24'h01FFFF, 16'd2048, 0, 0);
    run_op(4'd2, 16'd5, 1, 24'h000077, 1, 24'h0000FF, 16'd4096, 0, 0);
    // R10: ignored op keeps spare and pointer
    run_op(4'd12, 16'd99, 1, 24'h1, 1, 24'hFF, 16'd2048, 1, 0);
    run_op(4'd15, 16'd0, 0, 24'h0, 0, 24'h0, 16'd512, 0, 0);
    // R5 program setup with saved page reload
    run_op(4'd3, 16'h0044, 1, 24'h0A0B0C, 1, 24'hFFFFFF, 16'd2048, 0, 0);
    run_op(4'd3, 16'h0000, 0, 24'h000012, 1, 24'h00FFFF, 16'd512, 0, 0);
    // R6
    run_op(4'd4, 16'd7, 1, 24'h5, 1, 24'hFF, 16'd2048, 0, 0);
    // R7
    run_op(4'd5, 16'd0, 0, 24'h030201, 1, 24'hFFFFFF, 16'd2048, 0, 0);
    run_op(4'd6, 16'd0, 0, 24'h0, 0, 24'h0, 16'd2048, 0, 0);
    // R8
    run_op(4'd7, 16'h0000, 1, 24'h0, 0, 24'h0, 16'd512, 0, 0);
    run_op(4'd8, 16'd0, 0, 24'h0, 0, 24'h0, 16'd2048, 1, 0);
    run_op(4'd8, 16'd0, 0, 24'h0, 0, 24'h0, 16'd2048, 0, 0);
    // R11: request during busy ignored
    run_op(4'd3, 16'h0102, 1, 24'h445566, 1, 24'hFFFFFF, 16'd4096, 0, 1);
    for (int n = 0; n < 60; n++) begin
      logic [23:0] mk = 24'hFFFFFF >> (8 * ($urandom % 4));
      if ($urandom % 8 == 0) mk = 24'h01FFFF;
      run_op(4'($urandom % 11), 16'($urandom), 1'($urandom), 24'($urandom), 1'($urandom),
             mk, pick_pb(int'($urandom % 4)), 1'($urandom), 1'($urandom % 4 == 0));
    end
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL R11 watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule